// File: doc/BRIEF.md
# Selectable-Clock Input Sampler

This block latches a bus of general-purpose input pins into an input register that the rest of the peripheral reads. Register reads and interrupt detection use this register. It has two ways to take samples. In direct mode the register tracks the pins on every cycle of the bus clock. In strobe mode the register is loaded only when an external strobe pin makes a chosen transition. A second control bit selects whether that transition is the rising edge or the falling edge.

The pins and the strobe both pass through a short synchroniser chain into the bus clock domain. Strobe edges are found by comparing the synchronised strobe with a copy delayed by one cycle. In strobe mode the pin data is taken from the end of the pin synchroniser in the same cycle that the edge is detected, so the captured word is the one present on the pins at the strobe transition. Both control bits are expected to come from registers in the bus clock domain.

Top module: `pin_sampler`

## Requirements
- R1: With strobe mode off (`use_strobe_i` = 0), a pin value applied before rising clock edge k appears on `sampled_o` right after edge k+1 (two bus cycles), for every bit pattern.
- R2: With strobe mode on, a strobe transition applied before clock edge k loads the register at edge k+2. The output keeps its old value after edge k+1 and shows the pin value after edge k+2.
- R3: With strobe mode on and a quiet strobe, `sampled_o` does not change, however the pins move and however many bus cycles pass.
- R4: With strobe mode on and `strobe_fall_i` = 0, a 0-to-1 strobe transition loads the current pin value.
- R5: With strobe mode on and `strobe_fall_i` = 1, a 1-to-0 strobe transition loads the current pin value. A 0-to-1 transition leaves the register unchanged.
- R6: With strobe mode on and `strobe_fall_i` = 0, a 1-to-0 strobe transition leaves the register unchanged.
- R7: While `rst_n` is low, `sampled_o` is all zeros.
- R8: Turning strobe mode on keeps the last value taken in direct mode until the first selected strobe edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | WIDTH | Input pin bus, asynchronous |
| strobe_i | input | 1 | External sampling strobe pin, asynchronous |
| use_strobe_i | input | 1 | 1 selects strobe mode, 0 selects direct mode |
| strobe_fall_i | input | 1 | 1 makes the falling strobe edge active, 0 makes the rising edge active |
| sampled_o | output | WIDTH | Latched input value in the bus clock domain |

## Verification
A fault in the strobe edge detector shows up at the ports as a wrong load. Either the register takes a new word on the inactive strobe edge, or it fails to load on the active edge. Either error is visible at the third clock edge after the strobe moves. An extra or missing stage in the pin synchroniser moves the direct-mode update one cycle earlier or later, and the check made exactly two cycles after a pin change catches it. A register that wrongly follows the pins in strobe mode is caught after several quiet cycles, once the pins have changed with no strobe activity.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_pulse_t;

   // true when the detected pulse matches the selected active edge
   function automatic logic edge_selected(edge_pulse_t e, logic fall_sel);
      return fall_sel ? e.fall : e.rise;
   endfunction

endpackage

// File: rtl/sampler_sync.sv
module sampler_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] tap_early_o,
   output logic [WIDTH-1:0] tap_late_o
);
   localparam int LAST  = STAGES - 1;
   localparam int EARLY = STAGES - 2;

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_depth
         $error("sampler_sync: STAGES must lie between 2 and 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sampler_sync: WIDTH must be positive");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_i;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign tap_early_o = chain[EARLY];
   assign tap_late_o  = chain[LAST];
endmodule

// File: rtl/sampler_edge.sv
module sampler_edge
   import sampler_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strobe_i,
   output edge_pulse_t pulse_o
);
   logic strobe_early;
   logic strobe_sync;
   logic strobe_dly;

   sampler_sync #(.WIDTH(1), .STAGES(STAGES)) i_strobe_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .d_i        (strobe_i),
      .tap_early_o(strobe_early),
      .tap_late_o (strobe_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_dly <= 1'b0;
      else        strobe_dly <= strobe_sync;
   end

   assign pulse_o.rise = strobe_sync & ~strobe_dly;
   assign pulse_o.fall = ~strobe_sync & strobe_dly;

   // a detected edge never lasts longer than one bus cycle
   assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o.rise |=> !pulse_o.rise);
   assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o.fall |=> !pulse_o.fall);

   logic unused_early;
   assign unused_early = strobe_early;
endmodule

// File: rtl/sampler_capture.sv
module sampler_capture
   import sampler_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_strobe_i,
   input  logic             strobe_fall_i,
   input  edge_pulse_t      pulse_i,
   input  logic [WIDTH-1:0] data_direct_i,
   input  logic [WIDTH-1:0] data_aligned_i,
   output logic [WIDTH-1:0] sampled_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sampled_o <= '0;
      else if (!use_strobe_i)
         sampled_o <= data_direct_i;
      else if (edge_selected(pulse_i, strobe_fall_i))
         sampled_o <= data_aligned_i;
   end

   assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      use_strobe_i && !pulse_i.rise && !pulse_i.fall |=> $stable(sampled_o));
   assert_ignore_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      use_strobe_i && strobe_fall_i && pulse_i.rise |=> $stable(sampled_o));
   assert_ignore_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      use_strobe_i && !strobe_fall_i && pulse_i.fall |=> $stable(sampled_o));
endmodule

// File: rtl/pin_sampler.sv
module pin_sampler
   import sampler_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins_i,
   input  logic             strobe_i,
   input  logic             use_strobe_i,
   input  logic             strobe_fall_i,
   output logic [WIDTH-1:0] sampled_o
);
   localparam int WARM_W = $clog2(SYNC_STAGES + 1) + 1;

   logic [WIDTH-1:0] pins_early;
   logic [WIDTH-1:0] pins_late;
   edge_pulse_t      pulse;

   sampler_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_pin_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .d_i        (pins_i),
      .tap_early_o(pins_early),
      .tap_late_o (pins_late)
   );

   sampler_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe_i(strobe_i),
      .pulse_o (pulse)
   );

   sampler_capture #(.WIDTH(WIDTH)) i_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .use_strobe_i  (use_strobe_i),
      .strobe_fall_i (strobe_fall_i),
      .pulse_i       (pulse),
      .data_direct_i (pins_early),
      .data_aligned_i(pins_late),
      .sampled_o     (sampled_o)
   );

   // cycles since reset, so the direct-mode check never looks before reset
   logic [WARM_W-1:0] warm_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             warm_cnt <= '0;
      else if (warm_cnt < WARM_W'(SYNC_STAGES)) warm_cnt <= warm_cnt + 1'b1;
   end

   assert_direct_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt == WARM_W'(SYNC_STAGES)) && !use_strobe_i
      |=> sampled_o == $past(pins_i, SYNC_STAGES));
endmodule

// File: tb/test_pin_sampler.sv
`timescale 1ns/1ps
module test_pin_sampler;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] pins = 8'hA5;
   logic         strobe = 1'b0;
   logic         use_strobe = 1'b0;
   logic         fall_sel = 1'b0;
   logic [W-1:0] sampled;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   event         cmp_ev;

   always #10 clk = ~clk;

   pin_sampler #(.WIDTH(W), .SYNC_STAGES(2)) i_pin_sampler (
      .clk          (clk),
      .rst_n        (rst_n),
      .pins_i       (pins),
      .strobe_i     (strobe),
      .use_strobe_i (use_strobe),
      .strobe_fall_i(fall_sel),
      .sampled_o    (sampled)
   );

   // monitor: pops expected items and compares them with the output
   initial begin
      forever begin
         @(cmp_ev);
         while (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (sampled !== e) begin
               errors++;
               $display("FAIL %s: sampled_o=%h expected=%h", t, sampled, e);
            end
         end
      end
   end

   task automatic expect_val(input logic [W-1:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      -> cmp_ev;
      #1;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      expect_val('0, "R7 reset value");
      rst_n = 1'b1;
      step(3);

      // R1: direct mode, several patterns, two-cycle latency
      pins = 8'h3C; step(1);
      expect_val(8'hA5, "R1 not yet after one edge");
      step(1);
      expect_val(8'h3C, "R1 pattern 3C");
      foreach (exp_q[i]) ; // queue is empty here
      pins = 8'hFF; step(2); expect_val(8'hFF, "R1 pattern FF");
      pins = 8'h00; step(2); expect_val(8'h00, "R1 pattern 00");
      pins = 8'h5A; step(2); expect_val(8'h5A, "R1 pattern 5A");
      pins = 8'h81; step(2); expect_val(8'h81, "R1 pattern 81");

      // R8 / R3: strobe mode entered, quiet strobe holds last value
      use_strobe = 1'b1;
      pins = 8'hC3; step(6);
      expect_val(8'h81, "R8 hold after entering strobe mode");

      // R4: rising edge loads with rising edge active
      strobe = 1'b1; step(3);
      expect_val(8'hC3, "R4 rising edge capture");

      // R3: long quiet period with pin changes
      pins = 8'h11; step(4);
      pins = 8'h12; step(8);
      expect_val(8'hC3, "R3 quiet strobe holds");

      // R6: falling edge ignored while rising is active
      strobe = 1'b0; step(5);
      expect_val(8'hC3, "R6 falling edge ignored");

      strobe = 1'b1; step(3);
      expect_val(8'h12, "R4 second rising edge capture");

      // R5: falling edge active, rising ignored
      fall_sel = 1'b1;
      pins = 8'h22; step(3);
      strobe = 1'b0; step(3);
      expect_val(8'h22, "R5 falling edge capture");
      pins = 8'h44; step(3);
      strobe = 1'b1; step(5);
      expect_val(8'h22, "R5 rising edge ignored");
      strobe = 1'b0; step(3);
      expect_val(8'h44, "R5 falling edge capture after ignored rise");

      // R2: exact capture latency after strobe transition
      fall_sel = 1'b0;
      pins = 8'h99; step(3);
      strobe = 1'b1; step(2);
      expect_val(8'h44, "R2 no load after two edges");
      step(1);
      expect_val(8'h99, "R2 load after third edge");

      // R1: back to direct mode
      use_strobe = 1'b0;
      pins = 8'h77; step(2);
      expect_val(8'h77, "R1 direct mode restored");

      // R7: reset clears a nonzero value
      rst_n = 1'b0; step(1);
      expect_val('0, "R7 reset clears register");

      step(1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule